// File: doc/BRIEF.md
# Serial-Serial Multiplier with Column Ones Counters

This block multiplies two unsigned N-bit operands that arrive one bit per clock, least significant bit first, on two serial inputs. Each input step forms every partial-product bit that the newly arrived pair of bits makes possible. These are the cross terms of the new a bit with all earlier b bits, the cross terms of the new b bit with all earlier a bits, and the square term of the two new bits. As a result, the whole N×N partial-product matrix is gathered in N input steps. Each new partial-product bit comes from a single AND gate. It is added into a ones counter that belongs to its matrix column, so no adder tree or carry-save array sits in the accumulation loop.

A start pulse clears the operand history and all column counters. The N bits of each operand are presented in the N cycles that follow the start cycle. Once the last step has been counted, a final stage weights each column count by its power of two, sums the counts into the 2N-bit product, and raises a one-cycle done flag. The product stays on the output until the next result replaces it.

Top module: `ssm_col_mult`

## Requirements
- R1: While rst_ni is low, and after its release until the first result, product_o is zero and done_o is low.
- R2: A start_i pulse clears all column counters and stored operand bits. A start_i pulse arriving while an operation is in progress abandons that operation: it produces no done_o, and a fresh operation begins.
- R3: Bit k of each operand (k = 0 for the least significant bit) is sampled at the (k+1)-th rising edge after the edge that samples start_i high. All N bits of both operands are therefore taken in N consecutive cycles.
- R4: The result is the unsigned 2N-bit product a×b.
- R5: done_o is high for exactly one cycle, directly after the (N+2)-th rising edge that follows the edge that samples start_i. It is low in the cycle before.
- R6: product_o changes only in the cycle in which done_o is high, and holds its value at all other times, including across a new start_i.
- R7: Each column counter is floor(log2 N)+1 bits wide. Its count never exceeds the number of partial-product bits in its column, which is min(c+1, 2N-1-c) for column c.
- R8: In each input step, a column counter grows by the population count of that column's newly formed AND outputs. This is 0, 1 or 2, and the counters stay unchanged outside the accumulation steps.
- R9: a_bit_i and b_bit_i are ignored outside the N-cycle sampling window: they change neither the stored operand bits, the counters nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears state and begins a multiplication |
| a_bit_i | input | 1 | Serial multiplicand bit, LSB first |
| b_bit_i | input | 1 | Serial multiplier bit, LSB first |
| product_o | output | 2N | Unsigned product, held between results |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
On every cycle, assertions check the following:
- each column count stays within the column's capacity;
- each step's growth is no more than two;
- counters and stored operand bits stay still outside accumulation;
- done_o lasts one cycle;
- product_o moves only with done_o.

The bench's scenarios are what show arithmetic correctness against a×b. They also show the exact cycle of done_o, the abort-and-restart behaviour, and that toggling the serial inputs outside the window leaves the result untouched. The operand patterns used are all-zero, all-one, single-bit and random.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_SUM   = 2'd3
  } ssm_state_e;

  // bits of column c in an n x n matrix
  function automatic int col_cap(int n, int c);
    return (c + 1 < 2 * n - 1 - c) ? c + 1 : 2 * n - 1 - c;
  endfunction
endpackage

// File: rtl/ssm_seq.sv
module ssm_seq import ssm_pkg::*; #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          sample_en_o,
  output logic [IW-1:0] sample_idx_o,
  output logic          sum_en_o
);
  ssm_state_e   state_q;
  logic [IW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (start_i) begin
      state_q <= ST_LOAD;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          if (step_q == IW'(N - 1)) begin
            state_q <= ST_DRAIN;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_DRAIN: state_q <= ST_SUM;
        ST_SUM:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign sample_en_o  = (state_q == ST_LOAD) && !start_i;
  assign sample_idx_o = step_q;
  assign sum_en_o     = (state_q == ST_SUM) && !start_i;

  // R3: the load phase lasts exactly N cycles
  assert_load_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> (step_q == '0));
endmodule

// File: rtl/ssm_operand_stage.sv
module ssm_operand_stage #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          sample_en_i,
  input  logic [IW-1:0] sample_idx_i,
  input  logic          a_bit_i,
  input  logic          b_bit_i,
  output logic          acc_en_o,
  output logic [IW-1:0] acc_idx_o,
  output logic          a_new_o,
  output logic          b_new_o,
  output logic [N-1:0]  a_hist_o,
  output logic [N-1:0]  b_hist_o
);
  logic          acc_en_q, a_new_q, b_new_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  a_hist_q, b_hist_q;

  // stage 1: capture the incoming pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_en_q <= 1'b0;
      a_new_q  <= 1'b0;
      b_new_q  <= 1'b0;
      idx_q    <= '0;
    end else if (clr_i) begin
      acc_en_q <= 1'b0;
      a_new_q  <= 1'b0;
      b_new_q  <= 1'b0;
      idx_q    <= '0;
    end else begin
      acc_en_q <= sample_en_i;
      if (sample_en_i) begin
        a_new_q <= a_bit_i;
        b_new_q <= b_bit_i;
        idx_q   <= sample_idx_i;
      end
    end
  end

  // history written at the same edge the counters absorb the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hist_q <= '0;
      b_hist_q <= '0;
    end else if (clr_i) begin
      a_hist_q <= '0;
      b_hist_q <= '0;
    end else if (acc_en_q) begin
      a_hist_q[idx_q] <= a_new_q;
      b_hist_q[idx_q] <= b_new_q;
    end
  end

  assign acc_en_o  = acc_en_q;
  assign acc_idx_o = idx_q;
  assign a_new_o   = a_new_q;
  assign b_new_o   = b_new_q;
  assign a_hist_o  = a_hist_q;
  assign b_hist_o  = b_hist_q;

  // R9: stored operands do not move outside accumulation
  assert_hist_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_q && !clr_i) |=> ($stable(a_hist_q) && $stable(b_hist_q)));
endmodule

// File: rtl/ssm_pp_gen.sv
module ssm_pp_gen #(
  parameter int N    = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1,
  localparam int NCOL = 2 * N - 1
) (
  input  logic                 en_i,
  input  logic [IW-1:0]        idx_i,
  input  logic                 a_new_i,
  input  logic                 b_new_i,
  input  logic [N-1:0]         a_hist_i,
  input  logic [N-1:0]         b_hist_i,
  output logic [NCOL-1:0][1:0] inc_o
);
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      inc_o[c] = 2'd0;
      if (en_i) begin
        for (int j = 0; j < N; j++) begin
          if (j < int'(idx_i) && c == int'(idx_i) + j) begin
            inc_o[c] = inc_o[c] + 2'(a_new_i & b_hist_i[j])
                                + 2'(a_hist_i[j] & b_new_i);
          end
        end
        if (c == 2 * int'(idx_i)) inc_o[c] = inc_o[c] + 2'(a_new_i & b_new_i);
      end
    end
  end
endmodule

// File: rtl/ssm_col_counter.sv
module ssm_col_counter #(
  parameter int CW  = 4,
  parameter int CAP = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [1:0]    inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CW'(inc_i);
  end

  assign cnt_o = cnt_q;

  assert_col_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= CAP);
  assert_step_growth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q >= $past(cnt_q)) && ((cnt_q - $past(cnt_q)) <= CW'(2)));
endmodule

// File: rtl/ssm_col_sum.sv
module ssm_col_sum #(
  parameter int N    = 8,
  parameter int CW   = 4,
  localparam int NCOL = 2 * N - 1,
  localparam int PW   = 2 * N
) (
  input  logic [NCOL-1:0][CW-1:0] cnt_i,
  output logic [PW-1:0]           sum_o
);
  always_comb begin
    sum_o = '0;
    for (int c = 0; c < NCOL; c++) sum_o = sum_o + (PW'(cnt_i[c]) << c);
  end
endmodule

// File: rtl/ssm_col_mult.sv
module ssm_col_mult import ssm_pkg::*; #(
  parameter int N = 8,
  localparam int PW = 2 * N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          a_bit_i,
  input  logic          b_bit_i,
  output logic [PW-1:0] product_o,
  output logic          done_o
);
  localparam int IW   = (N > 1) ? $clog2(N) : 1;
  localparam int NCOL = 2 * N - 1;
  localparam int CW   = $clog2(N + 1);

  logic          sample_en, sum_en, acc_en, a_new, b_new;
  logic [IW-1:0] sample_idx, acc_idx;
  logic [N-1:0]  a_hist, b_hist;
  logic [NCOL-1:0][1:0]    col_inc;
  logic [NCOL-1:0][CW-1:0] col_cnt;
  logic [PW-1:0] col_total, product_q;
  logic          done_q;

  ssm_seq #(.N(N)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .sample_en_o (sample_en),
    .sample_idx_o(sample_idx),
    .sum_en_o    (sum_en)
  );

  ssm_operand_stage #(.N(N)) u_ops (
    .clk_i, .rst_ni,
    .clr_i       (start_i),
    .sample_en_i (sample_en),
    .sample_idx_i(sample_idx),
    .a_bit_i, .b_bit_i,
    .acc_en_o    (acc_en),
    .acc_idx_o   (acc_idx),
    .a_new_o     (a_new),
    .b_new_o     (b_new),
    .a_hist_o    (a_hist),
    .b_hist_o    (b_hist)
  );

  ssm_pp_gen #(.N(N)) u_pp (
    .en_i    (acc_en),
    .idx_i   (acc_idx),
    .a_new_i (a_new),
    .b_new_i (b_new),
    .a_hist_i(a_hist),
    .b_hist_i(b_hist),
    .inc_o   (col_inc)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    ssm_col_counter #(.CW(CW), .CAP(col_cap(N, c))) u_cnt (
      .clk_i, .rst_ni,
      .clr_i(start_i),
      .inc_i(col_inc[c]),
      .cnt_o(col_cnt[c])
    );
  end

  ssm_col_sum #(.N(N), .CW(CW)) u_sum (
    .cnt_i(col_cnt),
    .sum_o(col_total)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      product_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= sum_en;
      if (sum_en) product_q <= col_total;
    end
  end

  assign product_o = product_q;
  assign done_o    = done_q;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_product_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (product_o != $past(product_o)) |-> done_o);
  assert_cnt_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !acc_en) |=> $stable(col_cnt));
endmodule

// File: tb/tb_ssm_col_mult.sv
module tb_ssm_col_mult;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, a_bit_i = 1'b0, b_bit_i = 1'b0;
  logic [PW-1:0] product_o;
  logic          done_o;
  int            total = 0, bad = 0;

  always #4 clk = ~clk;

  ssm_col_mult #(.N(N)) dut (
    .clk_i(clk), .rst_ni, .start_i, .a_bit_i, .b_bit_i, .product_o, .done_o
  );

  function automatic logic [PW-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // R3 timing: start at edge E0, bit k at edge E(k+1), done after E(N+2)
  task automatic run_mult(logic [N-1:0] a, logic [N-1:0] b);
    logic [PW-1:0] prev;
    prev = product_o;
    @(negedge clk); start_i = 1'b1; a_bit_i = 1'($urandom); b_bit_i = 1'($urandom);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); start_i = 1'b0; a_bit_i = a[k]; b_bit_i = b[k];
    end
    @(negedge clk); a_bit_i = 1'($urandom); b_bit_i = 1'($urandom);  // R9 noise
    @(negedge clk);
    chk(!done_o, "R5 early", done_o, 0);
    chk(product_o == prev, "R6 hold", product_o, prev);
    a_bit_i = 1'($urandom); b_bit_i = 1'($urandom);
    @(negedge clk);
    chk(done_o, "R5 done", done_o, 1);
    chk(product_o == ref_mul(a, b), "R4 product", product_o, ref_mul(a, b));
    @(negedge clk);
    chk(!done_o, "R5 pulse", done_o, 0);
    chk(product_o == ref_mul(a, b), "R6 held", product_o, ref_mul(a, b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(product_o == 0 && !done_o, "R1 in reset", {product_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(product_o == 0 && !done_o, "R1 after reset", {product_o, done_o}, 0);

    run_mult('0, '0);
    run_mult('1, '1);          // R7: every column filled to capacity
    run_mult('1, '0);
    run_mult(8'h01, '1);
    run_mult(8'hAA, 8'h55);
    for (int i = 0; i < N; i += 3)   // R8: single partial products per step
      run_mult(N'(1) << i, N'(1) << (N - 1 - i));

    // R2: abandon a half-loaded operation
    @(negedge clk); start_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); start_i = 1'b0; a_bit_i = 1'b1; b_bit_i = 1'b1;
    end
    hold = product_o;
    run_mult(8'h0F, 8'h0F);
    chk(product_o == 16'h00E1, "R2 restart", product_o, 16'h00E1);

    // R2: restart late (during drain)
    @(negedge clk); start_i = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk); start_i = 1'b0; a_bit_i = 1'b1; b_bit_i = 1'b1;
    end
    run_mult(8'h03, 8'h05);
    chk(product_o == 16'd15, "R2 late restart", product_o, 15);

    // R9: noise while idle leaves output untouched
    hold = product_o;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); a_bit_i = 1'($urandom); b_bit_i = 1'($urandom);
      chk(!done_o && product_o == hold, "R9 idle", product_o, hold);
    end

    for (int i = 0; i < 24; i++) run_mult(N'($urandom), N'($urandom));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule